// File: doc/BRIEF.md
# Banked ROM Window and Bus Select Decoder

This block sits between an 8-bit processor's 16-bit address bus and the memories and expansion connector of a small board. Each bus address is turned into one active-low chip select: the on-board RAM, a 4 KB ROM window at the top of the address space, or the external expansion bus. A 256-byte page just below the ROM window is marked as an I/O page, so expansion cards that expect separate I/O cycles can be placed there. The bottom 256 bytes belong to the processor's own ports, registers and internal RAM. No select is driven there.

A small control register sits at address 0x0002. Its low three bits choose which of eight 4 KB ROM pages is seen in the window, and they drive the ROM's upper address lines. A fourth bit maps the window in or out. When the window is out, its addresses go to the expansion bus. Two more bits are free for general use. The register boots with the last ROM page mapped in, so the processor starts from it. A write lands on the clock edge that ends the write cycle, so the next access already uses the new mapping.

Top module: `rom_bank_decoder`

## Requirements
- R1: When reset ends, the page field is 7 and the enable bit is 1. The general-purpose bits are 0, so a read of 0x0002 returns 0x0F and `rom_hi` is 7.
- R2: A cycle with `phi2`=1, `rw`=0 and `addr`=0x0002 loads the register on that clock edge. `wdata[2:0]` goes to the page field, `wdata[3]` to the enable bit and `wdata[5:4]` to the general-purpose bits. The next access decodes with the new values. `ctl_rdata` returns {2'b00, gp, enable, page} while `addr`=0x0002, and 0x00 at any other address. `gp_out` shows bits 5:4.
- R3: `ctl_rdata[7:6]` always read 0, and writing ones to `wdata[7:6]` has no visible effect.
- R4: With `phi2`=1, addresses 0x0100–0x7FFF assert only `ram_cs_n` (low).
- R5: With `phi2`=1, addresses 0x8000–0xEEFF assert only `ext_cs_n`, and `ext_io` is 0.
- R6: Addresses 0xEF00–0xEFFF drive `ext_io` to 1, and with `phi2`=1 they assert only `ext_cs_n`. `ext_io` is 0 at every other address.
- R7: With the enable bit at 1 and `phi2`=1, addresses 0xF000–0xFFFF assert only `rom_cs_n`, and `rom_hi` equals the page field. With the enable bit at 0, the same range asserts only `ext_cs_n`. Changing the enable bit leaves the page field as written.
- R8: Addresses 0x0000–0x00FF assert no chip select.
- R9: All chip selects are active low. None is asserted while `phi2`=0, and at most one is low at any time.
- R10: `rom_we_n` goes low only when `phi2`=1, `rw`=0, the ROM window is selected and `rom_wp`=0. When `rom_wp`=1, a write to the enabled ROM window asserts neither `rom_we_n` nor `ext_cs_n`.
- R11: `rd_n` equals NOT(`phi2` AND `rw`), and `ext_rw` always equals `rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Valid bus phase qualifier |
| wdata | input | 8 | Processor write data |
| rom_wp | input | 1 | 1 = ROM write protected |
| ram_cs_n | output | 1 | On-board RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| ext_cs_n | output | 1 | Expansion bus select, active low |
| ext_io | output | 1 | 1 = I/O cycle, 0 = memory cycle on the expansion bus |
| rom_hi | output | 3 | ROM address lines 14:12 (page number) |
| rom_we_n | output | 1 | ROM write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| ext_rw | output | 1 | Read/write line forwarded to the expansion bus |
| ctl_rdata | output | 8 | Control register read data |
| gp_out | output | 2 | General-purpose register bits 5:4 |

## Verification
The hardest case to reach is an access to the ROM window in the cycle right after a register write changed the page or the enable bit. Uniform random addresses almost never hit 0x0002 and then 0xFxxx in a row. The random stimulus is therefore weighted: about one access in eight targets 0x0002, and one in eight targets the top page. This makes writes followed at once by window accesses, with and without write protection, common. Directed sequences also toggle the enable bit with bits 7:6 set in the write data, and check that the page survives.

// File: rtl/rom_bank_decoder.sv
module rom_bank_decoder #(
  parameter logic [15:0] CTL_ADDR = 16'h0002,
  parameter logic [7:0]  IO_PAGE  = 8'hEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rw,
  input  logic        phi2,
  input  logic [7:0]  wdata,
  input  logic        rom_wp,
  output logic        ram_cs_n,
  output logic        rom_cs_n,
  output logic        ext_cs_n,
  output logic        ext_io,
  output logic [2:0]  rom_hi,
  output logic        rom_we_n,
  output logic        rd_n,
  output logic        ext_rw,
  output logic [7:0]  ctl_rdata,
  output logic [1:0]  gp_out
);

  logic [2:0] page_q;
  logic       en_q;
  logic [1:0] gp_q;

  logic ctl_hit, ctl_wr;
  assign ctl_hit = (addr == CTL_ADDR);
  assign ctl_wr  = phi2 & ~rw & ctl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 3'b111;
      en_q   <= 1'b1;
      gp_q   <= 2'b00;
    end else if (ctl_wr) begin
      page_q <= wdata[2:0];
      en_q   <= wdata[3];
      gp_q   <= wdata[5:4];
    end
  end

  logic low_pg, ram_hit, top_hit, rom_hit, ext_hit;
  assign low_pg  = (addr[15:8] == 8'h00);
  assign ram_hit = ~addr[15] & ~low_pg;
  assign top_hit = (addr[15:12] == 4'hF);
  assign rom_hit = top_hit & en_q;
  assign ext_hit = addr[15] & ~rom_hit;

  assign ram_cs_n  = ~(phi2 & ram_hit);
  assign rom_cs_n  = ~(phi2 & rom_hit);
  assign ext_cs_n  = ~(phi2 & ext_hit);
  assign ext_io    = (addr[15:8] == IO_PAGE);
  assign rom_hi    = page_q;
  assign rom_we_n  = ~(phi2 & ~rw & rom_hit & ~rom_wp);
  assign rd_n      = ~(phi2 & rw);
  assign ext_rw    = rw;
  assign ctl_rdata = ctl_hit ? {2'b00, gp_q, en_q, page_q} : 8'h00;
  assign gp_out    = gp_q;

endmodule

// File: rtl/rom_bank_decoder_chk.sv
module rom_bank_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rw,
  input logic        phi2,
  input logic [7:0]  wdata,
  input logic        rom_wp,
  input logic        ram_cs_n,
  input logic        rom_cs_n,
  input logic        ext_cs_n,
  input logic        ext_io,
  input logic [2:0]  rom_hi,
  input logic        rom_we_n,
  input logic [7:0]  ctl_rdata,
  input logic [1:0]  gp_out
);

  // R9
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ram_cs_n, ~rom_cs_n, ~ext_cs_n}));

  // R9
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (ram_cs_n && rom_cs_n && ext_cs_n && rom_we_n));

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !rw && addr == 16'h0002) |=> (rom_hi == $past(wdata[2:0]) && gp_out == $past(wdata[5:4])));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !rw && addr == 16'h0002) |=> ($stable(rom_hi) && $stable(gp_out)));

  // R10
  rom_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_we_n |-> (!rom_cs_n && !rom_wp && !rw && ext_cs_n));

  // R6
  io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_io |-> (addr[15:8] == 8'hEF && ext_cs_n == !phi2));

  // R3
  resv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:6] == 2'b00);

endmodule

bind rom_bank_decoder rom_bank_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2), .wdata(wdata),
  .rom_wp(rom_wp), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .ext_cs_n(ext_cs_n),
  .ext_io(ext_io), .rom_hi(rom_hi), .rom_we_n(rom_we_n), .ctl_rdata(ctl_rdata),
  .gp_out(gp_out)
);

// File: tb/sim_rom_bank_decoder.sv
module sim_rom_bank_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic rw = 1'b1, phi2 = 1'b0, rom_wp = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic ram_cs_n, rom_cs_n, ext_cs_n, ext_io, rom_we_n, rd_n, ext_rw;
  logic [2:0] rom_hi;
  logic [7:0] ctl_rdata;
  logic [1:0] gp_out;

  int checks = 0, errors = 0;
  logic [2:0] page_m = 3'b111;
  logic en_m = 1'b1;
  logic [1:0] gp_m = 2'b00;

  always #2 clk = ~clk;

  rom_bank_decoder u0 (.*);

  function automatic logic [19:0] expect_out(logic [15:0] a, logic r, logic p, logic wp);
    logic low, ram, top, rom, ext, io;
    logic [7:0] rd;
    low = (a[15:8] == 8'h00);
    ram = p & !a[15] & !low;
    top = (a[15:12] == 4'hF);
    rom = p & top & en_m;
    ext = p & a[15] & !(top & en_m);
    io  = (a[15:8] == 8'hEF);
    rd  = (a == 16'h0002) ? {2'b00, gp_m, en_m, page_m} : 8'h00;
    return {~ram, ~rom, ~ext, io, page_m, ~(p & !r & rom & !wp), ~(p & r), r, rd, gp_m};
  endfunction

  function automatic string region_tag(logic [15:0] a);
    if (a == 16'h0002) return "R2";
    if (a[15:8] == 8'h00) return "R8";
    if (!a[15]) return "R4";
    if (a[15:8] == 8'hEF) return "R6";
    if (a[15:12] == 4'hF) return "R7";
    return "R5";
  endfunction

  task automatic access(input logic [15:0] a, input logic r, input logic p,
                        input logic [7:0] wd, input logic wp, input string tag);
    logic [19:0] act, exp;
    @(negedge clk);
    addr = a; rw = r; phi2 = p; wdata = wd; rom_wp = wp;
    #1;
    exp = expect_out(a, r, p, wp);
    act = {ram_cs_n, rom_cs_n, ext_cs_n, ext_io, rom_hi, rom_we_n, rd_n, ext_rw, ctl_rdata, gp_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rw=%b phi2=%b wp=%b actual=%h expected=%h", tag, a, r, p, wp, act, exp);
    end
    @(posedge clk);
    if (p && !r && a == 16'h0002) begin
      page_m = wd[2:0]; en_m = wd[3]; gp_m = wd[5:4];
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state readback
    access(16'h0002, 1'b1, 1'b1, 8'h00, 1'b1, "R1");
    access(16'hF000, 1'b1, 1'b1, 8'h00, 1'b1, "R1");
    // R8 bottom page, R4 RAM edges
    access(16'h00FF, 1'b1, 1'b1, 8'h00, 1'b1, "R8");
    access(16'h0100, 1'b1, 1'b1, 8'h00, 1'b1, "R4");
    access(16'h7FFF, 1'b0, 1'b1, 8'h00, 1'b1, "R4");
    // R5 expansion memory edges
    access(16'h8000, 1'b1, 1'b1, 8'h00, 1'b1, "R5");
    access(16'hEEFF, 1'b1, 1'b1, 8'h00, 1'b1, "R5");
    // R6 I/O page edges
    access(16'hEF00, 1'b1, 1'b1, 8'h00, 1'b1, "R6");
    access(16'hEFFF, 1'b0, 1'b1, 8'h00, 1'b1, "R6");
    // R9 no select outside valid phase
    access(16'h0100, 1'b1, 1'b0, 8'h00, 1'b1, "R9");
    access(16'hF800, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
    // R2 R3 write page 5, disable ROM, gp=10, reserved bits set
    access(16'h0002, 1'b0, 1'b1, 8'hE5, 1'b1, "R3");
    access(16'h0002, 1'b1, 1'b1, 8'h00, 1'b1, "R3");
    // R7 disabled window goes to expansion bus
    access(16'hF123, 1'b1, 1'b1, 8'h00, 1'b1, "R7");
    access(16'hFFFF, 1'b0, 1'b1, 8'h00, 1'b0, "R7");
    // R7 re-enable keeps page 5
    access(16'h0002, 1'b0, 1'b1, 8'h0D, 1'b1, "R7");
    access(16'hF456, 1'b1, 1'b1, 8'h00, 1'b1, "R7");
    // R10 protected and unprotected ROM writes
    access(16'hF456, 1'b0, 1'b1, 8'h00, 1'b1, "R10");
    access(16'hF456, 1'b0, 1'b1, 8'h00, 1'b0, "R10");
    // R11 strobes
    access(16'h1234, 1'b1, 1'b1, 8'h00, 1'b1, "R11");
    access(16'h1234, 1'b0, 1'b1, 8'h00, 1'b1, "R11");
    // R2 write with phi2 low is not a write
    access(16'h0002, 1'b0, 1'b0, 8'h00, 1'b1, "R2");
    access(16'h0002, 1'b1, 1'b1, 8'h00, 1'b1, "R2");
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 8)
        0: a = 16'h0002;
        1: a = {4'hF, 12'($urandom)};
        2: a = {8'hEF, 8'($urandom)};
        3: a = {8'h00, 8'($urandom)};
        default: a = 16'($urandom);
      endcase
      access(a, 1'($urandom), ($urandom % 5) != 0, 8'($urandom), 1'($urandom), region_tag(a));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule